// File: doc/BRIEF.md
# Bus Slave Cycle Termination Controller

This block ends slave read and write cycles on a shared processor bus whose termination line is active low and wired-OR among all slaves. When the block sees chip select while it is not the bus master, it latches the cycle type and captures write data. When the local core reports that it can finish the access, the block lowers its ready output. It then samples the termination line on every rising clock edge and ends the cycle on the first edge where the line is low. The clocks spent waiting for termination are counted, and the wait has no limit.

A control bit selects an internal acknowledge mode. With the bit clear, the termination pin is only an input, and the system loops ready back to it externally. With the bit set, the pin becomes an output while the block acts as a slave and stays an input while it is master. The block then drives the pin low with exactly the ready timing. After deasserting it, the block drives the pin high for one clock and then releases it. The bit can only be loaded by the first slave access after reset.

Top module: `slv_term_ctrl`

## Requirements
- R1: After reset, rdy_n is 1, term_oe is 0, cyc_end is 0, ack_mode is 0 and wait_cnt is 0.
- R2: A slave cycle starts on an edge where cs_n is sampled 0 and mst_mode is 0. rdy_n goes low after the first later edge where core_rdy is 1, and never earlier than after the second edge of the cycle. While mst_mode is 1, chip select starts no cycle.
- R3: While rdy_n is low, term_n_i is sampled on every rising edge. On the first edge where it is 0, rdy_n returns to 1 and cyc_end is 1 for exactly one clock.
- R4: wait_cnt is cleared when a cycle starts. It counts each edge where rdy_n is low and term_n_i is 1, saturating at 2^WCNT_W-1, and the cycle may stretch without limit.
- R5: For a write (rw_rd = 0), cap_data holds the value of data_in sampled on the second edge of the cycle. Later changes of data_in do not alter it, and a read leaves it unchanged.
- R6: A write with cfg_sel = 1 that terminates as the first slave access after reset loads ack_mode from data_in bit EN_BIT (default bit 0). Every later slave access leaves ack_mode unchanged.
- R7: While ack_mode is 0, term_oe stays 0.
- R8: While ack_mode is 1 and mst_mode is 0, term_oe is 1 whenever rdy_n is low, and term_n_o equals rdy_n. While mst_mode is 1, term_oe is 0.
- R9: After the driven termination is deasserted, term_oe stays 1 with term_n_o = 1 for one clock, then drops to 0.
- R10: After a cycle ends, no new cycle starts until cs_n has been sampled 1.
- R11: The access that sets ack_mode does not drive the pin in any of its clocks, including the clock after termination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mst_mode | input | 1 | 1 while this device owns the bus as master |
| cs_n | input | 1 | Chip select, active low |
| rw_rd | input | 1 | Cycle direction, 1 = read, 0 = write |
| cfg_sel | input | 1 | Access targets the control register holding the enable bit |
| data_in | input | DW | Bus write data |
| core_rdy | input | 1 | Local core can finish the access |
| term_n_i | input | 1 | Termination pin as seen on the bus, active low |
| rdy_n | output | 1 | Ready to terminate, active low, always driven |
| term_n_o | output | 1 | Value driven onto the termination pin |
| term_oe | output | 1 | Output enable for the termination pin |
| cyc_end | output | 1 | One-clock pulse after a cycle is terminated |
| wait_cnt | output | WCNT_W | Wait states of the current or last cycle |
| cap_data | output | DW | Captured write data |
| ack_mode | output | 1 | Internal acknowledge mode enabled |

## Verification
The enable-bit update and the termination sample fall on the same edge. The first access after reset is a configuration write carrying bit 0 set, so ack_mode rises on the very edge that ends the cycle, while the release logic would otherwise treat the following clock as part of a driven cycle. The bench terminates that cycle from outside. It checks that term_oe stays low during the ready phase and the clock after termination, and that the next access is then driven and released as required.

// File: rtl/slv_term_pkg.sv
package slv_term_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CAPT = 3'd1,
    ST_PREP = 3'd2,
    ST_RDY  = 3'd3,
    ST_REL  = 3'd4,
    ST_HOLD = 3'd5
  } sterm_st_e;

  // Next state of the slave cycle sequencer.
  function automatic sterm_st_e st_next(input sterm_st_e cur,
                                        input logic cs_n,
                                        input logic mst,
                                        input logic core_rdy,
                                        input logic term_n);
    sterm_st_e nx;
    case (cur)
      ST_IDLE: nx = (!cs_n && !mst) ? ST_CAPT : ST_IDLE;
      ST_CAPT: nx = core_rdy ? ST_RDY : ST_PREP;
      ST_PREP: nx = core_rdy ? ST_RDY : ST_PREP;
      ST_RDY:  nx = !term_n ? ST_REL : ST_RDY;
      ST_REL:  nx = cs_n ? ST_IDLE : ST_HOLD;
      ST_HOLD: nx = cs_n ? ST_IDLE : ST_HOLD;
      default: nx = ST_IDLE;
    endcase
    return nx;
  endfunction

  // Pin enable: drive in ready phase, keep driving high one clock after.
  function automatic logic pin_drive(input sterm_st_e cur,
                                     input logic ack_on,
                                     input logic mst,
                                     input logic drove_last);
    return ack_on && !mst &&
           ((cur == ST_RDY) || ((cur == ST_REL) && drove_last));
  endfunction

endpackage

// File: rtl/slv_term_fsm.sv
module slv_term_fsm
  import slv_term_pkg::*;
#(
  parameter int WCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              mst_mode,
  input  logic              core_rdy,
  input  logic              term_n,
  output sterm_st_e         st,
  output logic              term_hit,
  output logic [WCNT_W-1:0] wait_cnt
);

  localparam logic [WCNT_W-1:0] WMAX = '1;

  sterm_st_e st_q, st_d;
  logic      cyc_start;
  logic      wait_tick;

  function automatic logic [WCNT_W-1:0] wait_step(input logic [WCNT_W-1:0] c);
    return (c == WMAX) ? c : c + 1'b1;
  endfunction

  always_comb begin
    st_d      = st_next(st_q, cs_n, mst_mode, core_rdy, term_n);
    cyc_start = (st_q == ST_IDLE) && (st_d == ST_CAPT);
    term_hit  = (st_q == ST_RDY) && !term_n;
    wait_tick = (st_q == ST_RDY) && term_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      wait_cnt <= '0;
    end else begin
      st_q <= st_d;
      if (cyc_start)
        wait_cnt <= '0;
      else if (wait_tick)
        wait_cnt <= wait_step(wait_cnt);
    end
  end

  assign st = st_q;

endmodule

// File: rtl/slv_term_cfg.sv
module slv_term_cfg
  import slv_term_pkg::*;
#(
  parameter int DW     = 8,
  parameter int EN_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sterm_st_e     st,
  input  logic          rw_rd,
  input  logic          cfg_sel,
  input  logic [DW-1:0] data_in,
  input  logic          term_hit,
  output logic [DW-1:0] cap_data,
  output logic          ack_mode
);

  logic cyc_wr;
  logic cyc_cfg;
  logic locked;
  logic cap_now;
  logic load_en;

  always_comb begin
    cap_now = (st == ST_CAPT) && !rw_rd;
    load_en = term_hit && !locked && cyc_wr && cyc_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_wr   <= 1'b0;
      cyc_cfg  <= 1'b0;
      cap_data <= '0;
    end else if (st == ST_CAPT) begin
      cyc_wr  <= !rw_rd;
      cyc_cfg <= cfg_sel;
      if (cap_now)
        cap_data <= data_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      ack_mode <= 1'b0;
    end else if (term_hit) begin
      locked <= 1'b1;
      if (load_en)
        ack_mode <= cap_data[EN_BIT];
    end
  end

endmodule

// File: rtl/slv_term_pin.sv
module slv_term_pin
  import slv_term_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sterm_st_e st,
  input  logic      ack_mode,
  input  logic      mst_mode,
  output logic      term_n_o,
  output logic      term_oe
);

  logic drove_q;

  always_comb begin
    term_oe  = pin_drive(st, ack_mode, mst_mode, drove_q);
    term_n_o = (st != ST_RDY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drove_q <= 1'b0;
    else        drove_q <= term_oe;
  end

endmodule

// File: rtl/slv_term_ctrl.sv
module slv_term_ctrl
  import slv_term_pkg::*;
#(
  parameter int DW     = 8,
  parameter int WCNT_W = 8,
  parameter int EN_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mst_mode,
  input  logic              cs_n,
  input  logic              rw_rd,
  input  logic              cfg_sel,
  input  logic [DW-1:0]     data_in,
  input  logic              core_rdy,
  input  logic              term_n_i,
  output logic              rdy_n,
  output logic              term_n_o,
  output logic              term_oe,
  output logic              cyc_end,
  output logic [WCNT_W-1:0] wait_cnt,
  output logic [DW-1:0]     cap_data,
  output logic              ack_mode
);

  sterm_st_e st;
  logic      term_hit;

  slv_term_fsm #(.WCNT_W(WCNT_W)) fsm_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .mst_mode (mst_mode),
    .core_rdy (core_rdy),
    .term_n   (term_n_i),
    .st       (st),
    .term_hit (term_hit),
    .wait_cnt (wait_cnt)
  );

  slv_term_cfg #(.DW(DW), .EN_BIT(EN_BIT)) cfg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .rw_rd    (rw_rd),
    .cfg_sel  (cfg_sel),
    .data_in  (data_in),
    .term_hit (term_hit),
    .cap_data (cap_data),
    .ack_mode (ack_mode)
  );

  slv_term_pin pin_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .ack_mode (ack_mode),
    .mst_mode (mst_mode),
    .term_n_o (term_n_o),
    .term_oe  (term_oe)
  );

  assign rdy_n   = (st != ST_RDY);
  assign cyc_end = (st == ST_REL);

endmodule

// File: rtl/slv_term_chk.sv
module slv_term_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic mst_mode,
  input logic term_n_i,
  input logic rdy_n,
  input logic term_n_o,
  input logic term_oe,
  input logic cyc_end,
  input logic ack_mode
);

  AST_END_ON_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_n && !term_n_i) |=> (rdy_n && cyc_end)); // R3
  AST_END_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> !cyc_end); // R3
  AST_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_n && term_n_i) |=> !rdy_n); // R4
  AST_NO_DRIVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_mode |-> !term_oe); // R7
  AST_MASTER_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    mst_mode |-> !term_oe); // R8
  AST_PIN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    term_oe |-> (term_n_o == rdy_n)); // R8
  AST_RELEASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(term_oe) |-> $past(term_n_o)); // R9
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && !cs_n) |=> rdy_n); // R10

endmodule

bind slv_term_ctrl slv_term_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .mst_mode (mst_mode),
  .term_n_i (term_n_i),
  .rdy_n    (rdy_n),
  .term_n_o (term_n_o),
  .term_oe  (term_oe),
  .cyc_end  (cyc_end),
  .ack_mode (ack_mode)
);

// File: tb/slv_term_ctrl_tb.sv
module slv_term_ctrl_tb_top;

  localparam int DW = 8;
  localparam int WW = 8;
  localparam int NV = 6;

  // {rd, cfg, din[7:0], dly[3:0], waits[7:0], exp_ack}
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'h00, 4'd0, 8'd0,  1'b0},
    {1'b0, 1'b1, 8'h01, 4'd2, 8'd3,  1'b0},
    {1'b1, 1'b0, 8'h5A, 4'd1, 8'd0,  1'b0},
    {1'b0, 1'b0, 8'hA5, 4'd0, 8'd5,  1'b0},
    {1'b1, 1'b1, 8'h01, 4'd3, 8'd1,  1'b0},
    {1'b0, 1'b0, 8'h3C, 4'd0, 8'd12, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mst_mode = 1'b0;
  logic          cs_n = 1'b1;
  logic          rw_rd = 1'b1;
  logic          cfg_sel = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic          core_rdy = 1'b0;
  logic          ext_n = 1'b1;
  logic          term_pin;
  logic          rdy_n, term_n_o, term_oe, cyc_end, ack_mode;
  logic [WW-1:0] wait_cnt;
  logic [DW-1:0] cap_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] exp_cap = '0;

  always #10 clk = ~clk;

  // wired-OR active-low bus line
  assign term_pin = (term_oe ? term_n_o : 1'b1) & ext_n;

  slv_term_ctrl #(.DW(DW), .WCNT_W(WW), .EN_BIT(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .mst_mode(mst_mode), .cs_n(cs_n),
    .rw_rd(rw_rd), .cfg_sel(cfg_sel), .data_in(data_in),
    .core_rdy(core_rdy), .term_n_i(term_pin), .rdy_n(rdy_n),
    .term_n_o(term_n_o), .term_oe(term_oe), .cyc_end(cyc_end),
    .wait_cnt(wait_cnt), .cap_data(cap_data), .ack_mode(ack_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cs_n = 1'b1; core_rdy = 1'b0; ext_n = 1'b1; mst_mode = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 rdy_n", rdy_n, 1); chk("R1 term_oe", term_oe, 0);
    chk("R1 cyc_end", cyc_end, 0); chk("R1 ack_mode", ack_mode, 0);
    chk("R1 wait_cnt", wait_cnt, 0);
    rst_n = 1'b1;
    exp_cap = '0;
    @(negedge clk);
    chk("R1 rdy_n after release", rdy_n, 1);
  endtask

  task automatic do_cycle(input logic rd, input logic cfg, input logic [DW-1:0] din,
                          input int dly, input int waits, input logic drive,
                          input logic hold_cs);
    int guard;
    @(negedge clk);
    cs_n = 1'b0; rw_rd = rd; cfg_sel = cfg; data_in = din;
    core_rdy = (dly <= 1);
    @(negedge clk);                       // after first edge: capture state
    chk("R2 no early ready", rdy_n, 1);
    @(negedge clk);                       // after second edge
    data_in = ~din;                       // R5: later data must not be taken
    if (dly > 1) begin
      repeat (dly - 1) @(negedge clk);
      chk("R2 waits for core", rdy_n, 1);
      core_rdy = 1'b1;
      @(negedge clk);
    end
    guard = 0;
    while (rdy_n && guard < 50) begin @(negedge clk); guard++; end
    chk("R2 ready asserted", rdy_n, 0);
    chk("R8 drive in ready", term_oe, drive);
    if (drive) chk("R8 pin equals ready", term_n_o, 0);
    if (!drive) begin
      repeat (waits) @(negedge clk);
      chk("R4 still waiting", rdy_n, 0);
      ext_n = 1'b0;
    end
    @(negedge clk);                       // first clock after termination
    chk("R3 ready dropped", rdy_n, 1);
    chk("R3 end pulse", cyc_end, 1);
    chk("R4 wait count", wait_cnt, drive ? 0 : ((waits > 255) ? 255 : waits));
    chk("R9 driven high one clock", term_oe, drive);
    if (drive) chk("R9 level high", term_n_o, 1);
    if (!rd) exp_cap = din;
    chk("R5 captured data", cap_data, exp_cap);
    ext_n = 1'b1; core_rdy = 1'b0;
    if (hold_cs) begin
      core_rdy = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 no restart while selected", rdy_n, 1);
      core_rdy = 1'b0;
    end
    cs_n = 1'b1;
    @(negedge clk);
    chk("R9 released", term_oe, 0);
    chk("R3 end single clock", cyc_end, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();

    // table of slave cycles, acknowledge mode stays off (R6, R7)
    for (int i = 0; i < NV; i++) begin
      do_cycle(VEC[i][22], VEC[i][21], VEC[i][20:13], int'(VEC[i][12:9]),
               int'(VEC[i][8:1]), 1'b0, 1'b0);
      chk("R6 ack bit after table entry", ack_mode, VEC[i][0]);
    end

    // long stretch saturates the counter (R4)
    do_cycle(1'b1, 1'b0, 8'h00, 0, 300, 1'b0, 1'b0);
    // chip select held after end (R10)
    do_cycle(1'b0, 1'b0, 8'h77, 0, 2, 1'b0, 1'b1);

    // master mode ignores chip select (R2, R8)
    @(negedge clk);
    mst_mode = 1'b1; cs_n = 1'b0; core_rdy = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 master ignores select", rdy_n, 1);
    chk("R7 no drive in master", term_oe, 0);
    cs_n = 1'b1; core_rdy = 1'b0; mst_mode = 1'b0;
    @(negedge clk);

    // phase two: first access enables internal acknowledge (R6, R11)
    do_reset();
    do_cycle(1'b0, 1'b1, 8'h01, 0, 2, 1'b0, 1'b0);
    chk("R6 ack set by first access", ack_mode, 1);
    chk("R11 no drive after enabling", term_oe, 0);
    do_cycle(1'b1, 1'b0, 8'h00, 0, 0, 1'b1, 1'b0);
    do_cycle(1'b0, 1'b0, 8'hC3, 3, 0, 1'b1, 1'b0);
    do_cycle(1'b0, 1'b1, 8'h00, 0, 0, 1'b1, 1'b0);
    chk("R6 later write ignored", ack_mode, 1);

    @(negedge clk);
    mst_mode = 1'b1; cs_n = 1'b0; core_rdy = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 master keeps pin input", term_oe, 0);
    chk("R2 master no ready", rdy_n, 1);
    cs_n = 1'b1; core_rdy = 1'b0; mst_mode = 1'b0;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule